// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block gathers 72 level-sensitive interrupt lines into three groups: eight local sources and two 32-line peripheral banks. Each line has its own enable bit. Software sets enable bits through write-one-to-enable registers and clears them through write-one-to-disable registers, so one write changes several bits without a read-modify-write. A line counts as pending while its input is high and its enable bit is set. A single level interrupt output is raised while any line is pending.

The local status word is built so that a handler can often name the source with one read. It holds the eight local pending bits and one summary flag for each bank. It also holds direct copies of eleven chosen peripheral lines. A summary flag reports only pending lines of its bank that have no direct copy. A fast-interrupt routing word is kept as a plain read/write register with no effect on the output.

Register port: 6-bit byte address (bits 1:0 ignored), 32-bit write data with a write strobe, and combinational read data for the current address.

Top module: `banked_irq_regs`

## Requirements
- R1: A write to 0x10 (bank 1), 0x14 (bank 2) or 0x18 (local, data bits 7:0) sets every enable bit whose data bit is 1. Bits written as 0 keep their value.
- R2: A write to 0x1C (bank 1), 0x20 (bank 2) or 0x24 (local, data bits 7:0) clears every enable bit whose data bit is 1. Bits written as 0 keep their value.
- R3: Reading 0x04 returns irq_src_i[39:8] ANDed with the bank-1 enables, and reading 0x08 returns irq_src_i[71:40] ANDed with the bank-2 enables. Writes to 0x00, 0x04 and 0x08 change no state.
- R4: Bits 7:0 of the word at 0x00 are irq_src_i[7:0] ANDed with the local enables.
- R5: Bit 8 of the word at 0x00 is set when a bank-1 line other than 7, 9, 10, 18 or 19 is pending. Bit 9 is set when a bank-2 line other than 21–25 or 30 is pending.
- R6: Bits 10 to 14 of the word at 0x00 copy the pending state of bank-1 lines 7, 9, 10, 18 and 19, in that order.
- R7: Bits 15 to 20 of the word at 0x00 copy the pending state of bank-2 lines 21, 22, 23, 24, 25 and 30, in that order. Bits 31:21 read as 0.
- R8: irq_o is high exactly when at least one line of any group is pending.
- R9: After reset all enable bits and the fast-interrupt word are 0.
- R10: Reading 0x10 or 0x1C returns the bank-1 enables, 0x14 or 0x20 returns the bank-2 enables, and 0x18 or 0x24 returns the local enables in bits 7:0 with 0 above.
- R11: The word at 0x0C is a plain 32-bit read/write register with no effect on irq_o.
- R12: Reads from addresses 0x28 to 0x3C return 0, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the current address |
| addr_i | input | 6 | Byte address; bits 1:0 ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_src_i | input | 72 | Lines: [7:0] local, [39:8] bank 1, [71:40] bank 2 |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the interrupt lines and the register port are synchronous to clk_i and settle before each rising edge. They also assume that the port performs at most one access per cycle. The bench therefore changes every input on the falling edge and holds it through the next rising edge. The pending checks compare the output against the inputs of the same cycle. The lines are driven at random, so every shortcut and summary bit sees both values while any mix of enables is in effect. The random addresses also reach the unused range and the read-only words.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned LOCAL_N = 8;
  localparam int unsigned BANK_W  = 32;
  localparam int unsigned SRC_N   = LOCAL_N + 2 * BANK_W;
  localparam int unsigned IDX_W   = ADDR_W - 2;

  localparam int unsigned B1_SC_N = 5;
  localparam int unsigned B2_SC_N = 6;
  // status word layout
  localparam int unsigned SUM1_BIT  = LOCAL_N;
  localparam int unsigned SUM2_BIT  = LOCAL_N + 1;
  localparam int unsigned SC1_BASE  = LOCAL_N + 2;
  localparam int unsigned SC2_BASE  = SC1_BASE + B1_SC_N;
  localparam int unsigned STAT_USED = SC2_BASE + B2_SC_N;

  typedef enum logic [IDX_W-1:0] {
    IDX_STAT     = 4'd0,
    IDX_PEND_B1  = 4'd1,
    IDX_PEND_B2  = 4'd2,
    IDX_FIQ      = 4'd3,
    IDX_SET_B1   = 4'd4,
    IDX_SET_B2   = 4'd5,
    IDX_SET_LOC  = 4'd6,
    IDX_CLR_B1   = 4'd7,
    IDX_CLR_B2   = 4'd8,
    IDX_CLR_LOC  = 4'd9
  } reg_idx_e;

  function automatic int unsigned b1_sc_line(int unsigned k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      default: return 19;
    endcase
  endfunction

  function automatic int unsigned b2_sc_line(int unsigned k);
    if (k < 5) return 21 + k;
    return 30;
  endfunction

  function automatic logic [BANK_W-1:0] b1_sc_mask();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < B1_SC_N; k++) m[b1_sc_line(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [BANK_W-1:0] b2_sc_mask();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < B2_SC_N; k++) m[b2_sc_line(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (set_i) en_q <= en_q | bits_i;
    else if (clr_i) en_q <= en_q & ~bits_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_pend_gate.sv
module irq_pend_gate #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] pend_o,
  output logic         any_o
);
  assign pend_o = line_i & en_i;
  assign any_o  = |pend_o;
endmodule

// File: rtl/irq_stat_word.sv
module irq_stat_word
  import banked_irq_pkg::*;
(
  input  logic [LOCAL_N-1:0] pend_loc_i,
  input  logic [BANK_W-1:0]  pend_b1_i,
  input  logic [BANK_W-1:0]  pend_b2_i,
  output logic [DATA_W-1:0]  stat_o
);
  localparam logic [BANK_W-1:0] SC1_MASK = b1_sc_mask();
  localparam logic [BANK_W-1:0] SC2_MASK = b2_sc_mask();

  logic [STAT_USED-1:0] used;

  assign used[LOCAL_N-1:0] = pend_loc_i;
  assign used[SUM1_BIT]    = |(pend_b1_i & ~SC1_MASK);
  assign used[SUM2_BIT]    = |(pend_b2_i & ~SC2_MASK);

  for (genvar k = 0; k < B1_SC_N; k++) begin : g_sc1
    assign used[SC1_BASE + k] = pend_b1_i[b1_sc_line(k)];
  end
  for (genvar k = 0; k < B2_SC_N; k++) begin : g_sc2
    assign used[SC2_BASE + k] = pend_b2_i[b2_sc_line(k)];
  end

  assign stat_o = {{(DATA_W - STAT_USED){1'b0}}, used};
endmodule

// File: rtl/banked_irq_regs.sv
module banked_irq_regs
  import banked_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [SRC_N-1:0]  irq_src_i,
  output logic              irq_o
);
  localparam int unsigned B1_LO = LOCAL_N;
  localparam int unsigned B2_LO = LOCAL_N + BANK_W;

  logic [IDX_W-1:0]   idx;
  logic [LOCAL_N-1:0] en_loc, pend_loc;
  logic [BANK_W-1:0]  en_b1, en_b2, pend_b1, pend_b2;
  logic               any_loc, any_b1, any_b2;
  logic [DATA_W-1:0]  stat_word, fiq_q;

  assign idx = addr_i[ADDR_W-1:2];

  irq_en_bank #(.W(LOCAL_N)) i_en_loc (
    .clk_i, .rst_ni,
    .set_i (we_i && idx == IDX_SET_LOC),
    .clr_i (we_i && idx == IDX_CLR_LOC),
    .bits_i(wdata_i[LOCAL_N-1:0]),
    .en_o  (en_loc)
  );
  irq_en_bank #(.W(BANK_W)) i_en_b1 (
    .clk_i, .rst_ni,
    .set_i (we_i && idx == IDX_SET_B1),
    .clr_i (we_i && idx == IDX_CLR_B1),
    .bits_i(wdata_i[BANK_W-1:0]),
    .en_o  (en_b1)
  );
  irq_en_bank #(.W(BANK_W)) i_en_b2 (
    .clk_i, .rst_ni,
    .set_i (we_i && idx == IDX_SET_B2),
    .clr_i (we_i && idx == IDX_CLR_B2),
    .bits_i(wdata_i[BANK_W-1:0]),
    .en_o  (en_b2)
  );

  irq_pend_gate #(.W(LOCAL_N)) i_pend_loc (
    .line_i(irq_src_i[LOCAL_N-1:0]), .en_i(en_loc),
    .pend_o(pend_loc), .any_o(any_loc)
  );
  irq_pend_gate #(.W(BANK_W)) i_pend_b1 (
    .line_i(irq_src_i[B1_LO +: BANK_W]), .en_i(en_b1),
    .pend_o(pend_b1), .any_o(any_b1)
  );
  irq_pend_gate #(.W(BANK_W)) i_pend_b2 (
    .line_i(irq_src_i[B2_LO +: BANK_W]), .en_i(en_b2),
    .pend_o(pend_b2), .any_o(any_b2)
  );

  irq_stat_word i_stat (
    .pend_loc_i(pend_loc), .pend_b1_i(pend_b1), .pend_b2_i(pend_b2),
    .stat_o    (stat_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    fiq_q <= '0;
    else if (we_i && idx == IDX_FIQ) fiq_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    case (idx)
      IDX_STAT:                rdata_o = stat_word;
      IDX_PEND_B1:             rdata_o = pend_b1;
      IDX_PEND_B2:             rdata_o = pend_b2;
      IDX_FIQ:                 rdata_o = fiq_q;
      IDX_SET_B1, IDX_CLR_B1:  rdata_o = en_b1;
      IDX_SET_B2, IDX_CLR_B2:  rdata_o = en_b2;
      IDX_SET_LOC, IDX_CLR_LOC: rdata_o[LOCAL_N-1:0] = en_loc;
      default:                 rdata_o = '0;
    endcase
  end

  assign irq_o = any_loc | any_b1 | any_b2;
endmodule

// File: rtl/banked_irq_chk.sv
module banked_irq_chk
  import banked_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [SRC_N-1:0]  irq_src_i,
  input logic              irq_o,
  input logic [LOCAL_N-1:0] en_loc,
  input logic [BANK_W-1:0] en_b1,
  input logic [BANK_W-1:0] en_b2
);
  logic [3:0] idx;
  assign idx = addr_i[ADDR_W-1:2];

  AST_SET_B1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == 4'd4) |=> en_b1 == ($past(en_b1) | $past(wdata_i))); // R1
  AST_SET_LOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == 4'd6) |=> en_loc == ($past(en_loc) | $past(wdata_i[LOCAL_N-1:0]))); // R1
  AST_CLR_B2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == 4'd8) |=> en_b2 == ($past(en_b2) & ~$past(wdata_i))); // R2
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(en_b1) && $stable(en_b2) && $stable(en_loc))); // R3
  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(irq_src_i & {en_b2, en_b1, en_loc}))); // R8

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (en_loc == '0 && en_b1 == '0 && en_b2 == '0 && !irq_o); // R9
    end
  end
endmodule

bind banked_irq_regs banked_irq_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_src_i(irq_src_i), .irq_o(irq_o),
  .en_loc(en_loc), .en_b1(en_b1), .en_b2(en_b2)
);

// File: tb/test_banked_irq_regs.sv
module test_banked_irq_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [71:0] irq_src_i = '0;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  bit [7:0]  m_loc;
  bit [31:0] m_b1, m_b2, m_fiq;

  always #5 clk_i = ~clk_i;

  banked_irq_regs i_banked_irq_regs (.*);

  function automatic bit [31:0] m_stat(bit [71:0] s);
    bit [31:0] r;
    bit [31:0] p1, p2;
    int sc1[5] = '{7, 9, 10, 18, 19};
    int sc2[6] = '{21, 22, 23, 24, 25, 30};
    p1 = s[39:8] & m_b1;
    p2 = s[71:40] & m_b2;
    r = '0;
    r[7:0] = s[7:0] & m_loc;
    foreach (sc1[k]) begin
      r[10+k] = p1[sc1[k]];
      p1[sc1[k]] = 1'b0;
    end
    foreach (sc2[k]) begin
      r[15+k] = p2[sc2[k]];
      p2[sc2[k]] = 1'b0;
    end
    r[8] = (p1 != 0);
    r[9] = (p2 != 0);
    return r;
  endfunction

  function automatic bit [31:0] m_read(bit [5:0] a, bit [71:0] s);
    case (a[5:2])
      0: return m_stat(s);
      1: return s[39:8] & m_b1;
      2: return s[71:40] & m_b2;
      3: return m_fiq;
      4, 7: return m_b1;
      5, 8: return m_b2;
      6, 9: return {24'd0, m_loc};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_now();
    bit [31:0] e;
    e = m_read(addr_i, irq_src_i);
    chk("R8 irq_o", {31'd0, irq_o},
        {31'd0, ((irq_src_i & {m_b2, m_b1, m_loc}) != 0)});
    case (addr_i[5:2])
      0: begin
        chk("R4 local bits", {24'd0, rdata_o[7:0]}, {24'd0, e[7:0]});
        chk("R5 summary bits", {30'd0, rdata_o[9:8]}, {30'd0, e[9:8]});
        chk("R6 bank1 copies", {27'd0, rdata_o[14:10]}, {27'd0, e[14:10]});
        chk("R7 bank2 copies/zero", {15'd0, rdata_o[31:15]}, {15'd0, e[31:15]});
      end
      1, 2: chk("R3 bank pending", rdata_o, e);
      3: chk("R11 fiq word", rdata_o, e);
      4, 5, 6, 7, 8, 9: chk("R10 enable read", rdata_o, e);
      default: chk("R12 unmapped read", rdata_o, e);
    endcase
  endtask

  task automatic step(bit we, bit [5:0] a, bit [31:0] d, bit [71:0] s);
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d; irq_src_i = s;
    #2;
    check_now();
    @(posedge clk_i);
    if (we && rst_ni) begin
      case (a[5:2])
        3: m_fiq = d;
        4: m_b1 = m_b1 | d;
        5: m_b2 = m_b2 | d;
        6: m_loc = m_loc | d[7:0];
        7: m_b1 = m_b1 & ~d;
        8: m_b2 = m_b2 & ~d;
        9: m_loc = m_loc & ~d[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic rd(string tag, bit [5:0] a, bit [71:0] s, bit [31:0] exp);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a; irq_src_i = s;
    #2;
    chk(tag, rdata_o, exp);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [95:0] rnd;
    m_loc = '0; m_b1 = '0; m_b2 = '0; m_fiq = '0;
    // R9: writes during reset are lost
    step(1'b1, 6'h10, 32'hFFFF_FFFF, '1);
    step(1'b0, 6'h18, 32'h0, '1);
    rd("R9 reset fiq", 6'h0C, '1, 32'h0);
    rd("R9 reset enables", 6'h14, '1, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd("R9 after reset", 6'h00, '1, 32'h0);

    // R1: set bank1 shortcut lines plus line 0
    step(1'b1, 6'h10, 32'h000C_0681, '0);
    rd("R1 set bank1", 6'h1C, '0, 32'h000C_0681);
    step(1'b1, 6'h10, 32'h0000_0002, '0);
    rd("R1 zero bits kept", 6'h10, '0, 32'h000C_0683);
    rd("R6 shortcuts only", 6'h00, {32'd0, 32'h000C_0680, 8'd0}, 32'h0000_7C00);
    rd("R5 summary bank1", 6'h00, {32'd0, 32'h0000_0001, 8'd0}, 32'h0000_0100);
    // R2: clear part
    step(1'b1, 6'h1C, 32'h0008_0001, '0);
    rd("R2 clear bank1", 6'h10, '0, 32'h0004_0682);
    // R7 bank2 shortcuts and summary
    step(1'b1, 6'h14, 32'h43E0_0000, '0);
    rd("R7 bank2 copies", 6'h00, {32'hFFFF_FFFF, 40'd0}, 32'h001F_8000);
    step(1'b1, 6'h14, 32'h0000_0010, '0);
    rd("R5 summary bank2", 6'h00, {32'h0000_0010, 40'd0}, 32'h0000_0200);
    step(1'b1, 6'h20, 32'hFFFF_FFFF, '0);
    rd("R2 clear bank2", 6'h14, '0, 32'h0);
    // R3: write to pending words ignored
    step(1'b1, 6'h04, 32'hFFFF_FFFF, '0);
    rd("R3 write ignored", 6'h10, '0, 32'h0004_0682);
    // R11: fiq word plain, no irq effect
    step(1'b1, 6'h0C, 32'hA5A5_5A5A, '0);
    rd("R11 fiq readback", 6'h0C, '0, 32'hA5A5_5A5A);
    chk("R11 no irq", {31'd0, irq_o}, 32'd0);
    // R12: unmapped write has no effect
    step(1'b1, 6'h2C, 32'hFFFF_FFFF, '0);
    rd("R12 unmapped", 6'h2C, '1, 32'h0);
    rd("R12 state kept", 6'h18, '0, 32'h0);

    for (int i = 0; i < 2000; i++) begin
      rnd = {$urandom, $urandom, $urandom};
      step(($urandom % 3) == 0, 6'($urandom % 64), $urandom, rnd[71:0]);
    end
    step(1'b0, 6'h00, 32'h0, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule